// File: doc/BRIEF.md
# Dual-Bank Timed Pattern Output Sequencer

This block stores output patterns in two ten-entry FIFO banks and releases them one at a time, paced by an external tach or frequency input. Every entry pairs a 16-bit compare value with an 8-bit pattern. An event counter steps once for each selected edge of the external input. When the counter equals the compare value of the entry at the head of the active bank, that entry's pattern is loaded into the output register and the entry is consumed.

A host fills the banks through one write channel that carries a bank select. Back-pressure rule: a write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the bank named by `wr_bank` holds ten entries. A writer that sees `wr_ready` low holds its data and waits. In dual mode the output side drains bank A, then bank B, then goes back to bank A. In single mode only bank A is used. `bank_flag` shows which bank is driving the outputs. An interrupt line latches either the end-of-bank strobe or each match, chosen by a select input. The host clears it by writing one.

Top module: `dbp_pattern_fifo`

## Requirements
- R1: The counter steps once per rising edge of `tach_in` when `cfg_fall_edge` is 0, and once per falling edge when it is 1. The input passes through a two-flop synchronizer first, and the other edge does not count.
- R2: When the active bank is not empty and the counter equals the head entry's compare value, `pat_out` takes that entry's pattern on the next clock edge. `match_pulse` is high for that one cycle and the entry is consumed. `pat_out` does not change at any other time.
- R3: With `cfg_single_bank` at 0, every entry of bank A is output first, then every entry of bank B, and the order repeats. `bank_flag` reads 0 while bank A is active and 1 while bank B is active. It changes only when a bank finishes or when the mode input changes.
- R4: With `cfg_single_bank` at 1, only bank A is output and `bank_flag` reads 0. Entries written to bank B have no effect on `pat_out`.
- R5: Each time the output side returns to bank A because the last bank in use has emptied, the counter returns to 0.
- R6: A 1-to-0 transition of `cfg_single_bank` that follows a 0-to-1 transition sets `bank_flag` to 0 on the next edge and clears the counter, so output resumes from bank A.
- R7: `strobe_pulse` is high for one cycle, together with `match_pulse`, when a match consumes the last entry held in the active bank.
- R8: With `cfg_irq_match` at 0, a rising edge of `strobe_pulse` sets `irq`. With it at 1, every `match_pulse` sets `irq`. Either way `irq` rises one cycle after the source.
- R9: `irq` stays set until a cycle with `irq_clr` high clears it. If a new source event arrives in the same cycle, the set wins.
- R10: Write channel: `wr_bank` 0 selects bank A and 1 selects bank B. Each bank accepts ten entries. `wr_ready` goes low while the selected bank is full, and is high otherwise.
- R11: After reset, `pat_out` is 0, `bank_flag` is 0, `irq` is 0, both banks are empty and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_bank | input | 1 | Target bank: 0 = A, 1 = B |
| wr_cmp | input | 16 | Compare value of the written entry |
| wr_pat | input | 8 | Pattern of the written entry |
| wr_ready | output | 1 | Selected bank can accept an entry |
| tach_in | input | 1 | External count input (asynchronous) |
| cfg_fall_edge | input | 1 | 0 = count rising edges, 1 = count falling edges |
| cfg_single_bank | input | 1 | 0 = both banks alternate, 1 = bank A only |
| cfg_irq_match | input | 1 | 0 = interrupt on end-of-bank strobe, 1 = on each match |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| pat_out | output | 8 | Pattern register |
| bank_flag | output | 1 | Active bank: 0 = A, 1 = B |
| match_pulse | output | 1 | One-cycle pulse on each match |
| strobe_pulse | output | 1 | One-cycle pulse when a bank empties by a match |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that each level of `cfg_single_bank` lasts at least one clock edge, so that the mode input is the only thing that can move `bank_flag` apart from an end-of-bank strobe. They also assume that the configuration inputs are stable around the clock edge and that `tach_in` stays at each level for at least two clocks, so the synchronizer sees every edge. The stimulus drives every input on the falling clock edge. It holds each `tach_in` level for six clocks and holds each mode level for a whole cycle or more. It changes the edge select only while `tach_in` is low and stable.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  // Bank identifiers; the sequencing order (A then B) is behavioural.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  localparam int unsigned NBANK = 2;
endpackage

// File: rtl/dbp_tach_edge.sv
module dbp_tach_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  input  logic fall_sel,
  output logic tick
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tach_in};
      prev_q <= sync_q[1];
    end
  end

  // Edge chosen by the select: rising when 0, falling when 1.
  always_comb begin
    if (fall_sel) tick = prev_q & ~sync_q[1];
    else          tick = sync_q[1] & ~prev_q;
  end
endmodule

// File: rtl/dbp_bank_fifo.sv
module dbp_bank_fifo #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned W     = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         last
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign last    = (cnt == CW'(1));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dbp_out_seq.sv
module dbp_out_seq
  import dbp_pkg::*;
#(
  parameter int unsigned CMP_W = 16,
  parameter int unsigned PAT_W = 8,
  localparam int unsigned ENT_W = CMP_W + PAT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        single_mode,
  input  logic [NBANK-1:0][ENT_W-1:0] head,
  input  logic [NBANK-1:0]            empty,
  input  logic [NBANK-1:0]            last,
  output logic [NBANK-1:0]            pop,
  output logic [PAT_W-1:0]            pat_out,
  output logic                        bank_flag,
  output logic                        match_pulse,
  output logic                        strobe_pulse
);
  logic [CMP_W-1:0] cnt_q;
  logic [PAT_W-1:0] pat_q;
  bank_e            sel_q, eff;
  logic             mode_q, match_q, strobe_q;
  logic [ENT_W-1:0] head_e;
  logic             hit, done, wrap, rewind;

  // Single mode pins the output side to bank A.
  assign eff    = single_mode ? BANK_A : sel_q;
  assign head_e = head[eff];
  assign hit    = ~empty[eff] && (cnt_q == head_e[ENT_W-1:PAT_W]);
  assign done   = hit && last[eff];
  assign wrap   = done && (single_mode || (eff == BANK_B));
  assign rewind = mode_q && !single_mode;

  for (genvar g = 0; g < NBANK; g++) begin : g_pop
    assign pop[g] = hit && (eff == bank_e'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pat_q    <= '0;
      sel_q    <= BANK_A;
      mode_q   <= 1'b0;
      match_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mode_q   <= single_mode;
      match_q  <= hit;
      strobe_q <= done;
      if (hit) pat_q <= head_e[PAT_W-1:0];

      if (rewind || single_mode || wrap) sel_q <= BANK_A;
      else if (done)                     sel_q <= BANK_B;

      if (rewind || wrap) cnt_q <= '0;
      else if (tick)      cnt_q <= cnt_q + CMP_W'(1);
    end
  end

  assign pat_out      = pat_q;
  assign bank_flag    = eff;
  assign match_pulse  = match_q;
  assign strobe_pulse = strobe_q;
endmodule

// File: rtl/dbp_irq_ctl.sv
module dbp_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic match_pulse,
  input  logic strobe_pulse,
  input  logic sel_match,
  input  logic clr,
  output logic irq
);
  logic strobe_d, irq_q, src;

  assign src = sel_match ? match_pulse : (strobe_pulse & ~strobe_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      strobe_d <= strobe_pulse;
      irq_q    <= (irq_q & ~clr) | src;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/dbp_pattern_fifo.sv
module dbp_pattern_fifo
  import dbp_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CMP_W = 16,
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_bank,
  input  logic [CMP_W-1:0] wr_cmp,
  input  logic [PAT_W-1:0] wr_pat,
  output logic             wr_ready,
  input  logic             tach_in,
  input  logic             cfg_fall_edge,
  input  logic             cfg_single_bank,
  input  logic             cfg_irq_match,
  input  logic             irq_clr,
  output logic [PAT_W-1:0] pat_out,
  output logic             bank_flag,
  output logic             match_pulse,
  output logic             strobe_pulse,
  output logic             irq
);
  localparam int unsigned ENT_W = CMP_W + PAT_W;

  logic                        tick;
  logic [NBANK-1:0][ENT_W-1:0] head;
  logic [NBANK-1:0]            empty, last, full, pop, push;

  dbp_tach_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tach_in  (tach_in),
    .fall_sel (cfg_fall_edge),
    .tick     (tick)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign push[g] = wr_valid && (wr_bank == g[0]);
    dbp_bank_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[g]),
      .din   ({wr_cmp, wr_pat}),
      .full  (full[g]),
      .pop   (pop[g]),
      .dout  (head[g]),
      .empty (empty[g]),
      .last  (last[g])
    );
  end

  assign wr_ready = ~full[wr_bank];

  dbp_out_seq #(.CMP_W(CMP_W), .PAT_W(PAT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .single_mode  (cfg_single_bank),
    .head         (head),
    .empty        (empty),
    .last         (last),
    .pop          (pop),
    .pat_out      (pat_out),
    .bank_flag    (bank_flag),
    .match_pulse  (match_pulse),
    .strobe_pulse (strobe_pulse)
  );

  dbp_irq_ctl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .match_pulse  (match_pulse),
    .strobe_pulse (strobe_pulse),
    .sel_match    (cfg_irq_match),
    .clr          (irq_clr),
    .irq          (irq)
  );
endmodule

// File: rtl/dbp_pattern_fifo_chk.sv
module dbp_pattern_fifo_chk #(
  parameter int unsigned CMP_W = 16,
  parameter int unsigned PAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_single_bank,
  input logic             cfg_irq_match,
  input logic             irq_clr,
  input logic [PAT_W-1:0] pat_out,
  input logic             bank_flag,
  input logic             match_pulse,
  input logic             strobe_pulse,
  input logic             irq
);
  AST_PAT_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> $stable(pat_out)); // R2

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_flag) |-> (strobe_pulse || !$stable(cfg_single_bank))); // R3

  AST_SINGLE_BANK_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single_bank && $past(cfg_single_bank)) |-> !bank_flag); // R4

  AST_REWIND_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_single_bank) && !cfg_single_bank) |=> !bank_flag); // R6

  AST_STROBE_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pulse |-> match_pulse); // R7

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_match && match_pulse) |=> irq); // R8

  AST_IRQ_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_match && $rose(strobe_pulse)) |=> irq); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R9
endmodule

bind dbp_pattern_fifo dbp_pattern_fifo_chk #(.CMP_W(CMP_W), .PAT_W(PAT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_single_bank (cfg_single_bank),
  .cfg_irq_match   (cfg_irq_match),
  .irq_clr         (irq_clr),
  .pat_out         (pat_out),
  .bank_flag       (bank_flag),
  .match_pulse     (match_pulse),
  .strobe_pulse    (strobe_pulse),
  .irq             (irq)
);

// File: tb/dbp_pattern_fifo_bench.sv
`timescale 1ns/1ps
module dbp_pattern_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_bank = 1'b0;
  logic [15:0] wr_cmp = '0;
  logic [7:0] wr_pat = '0;
  logic       wr_ready;
  logic       tach_in = 1'b0, cfg_fall_edge = 1'b0, cfg_single_bank = 1'b0;
  logic       cfg_irq_match = 1'b0, irq_clr = 1'b0;
  logic [7:0] pat_out;
  logic       bank_flag, match_pulse, strobe_pulse, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbp_pattern_fifo u_dbp_pattern_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bank(wr_bank),
    .wr_cmp(wr_cmp), .wr_pat(wr_pat), .wr_ready(wr_ready), .tach_in(tach_in),
    .cfg_fall_edge(cfg_fall_edge), .cfg_single_bank(cfg_single_bank),
    .cfg_irq_match(cfg_irq_match), .irq_clr(irq_clr), .pat_out(pat_out),
    .bank_flag(bank_flag), .match_pulse(match_pulse),
    .strobe_pulse(strobe_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic b, input int c, input int p);
    @(negedge clk);
    wr_valid = 1'b1; wr_bank = b; wr_cmp = 16'(c); wr_pat = 8'(p);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic half(input logic lvl);
    @(negedge clk);
    tach_in = lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse();
    half(1'b1);
    half(1'b0);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pat", pat_out, 0);
    chk("R11 flag", bank_flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 ready", wr_ready, 1);

    // R10 fill bank A to capacity, bank B with later compare values
    for (int k = 0; k < 10; k++) put(1'b0, k + 1, 8'h10 + k);
    for (int k = 0; k < 10; k++) put(1'b1, k + 11, 8'h40 + k);
    @(negedge clk);
    wr_bank = 1'b0;
    #1 chk("R10 full A ready low", wr_ready, 0);
    wr_bank = 1'b1;
    #1 chk("R10 full B ready low", wr_ready, 0);

    // R3 / R1 / R2 dual-bank sweep of twenty counts
    for (int n = 1; n <= 20; n++) begin
      pulse();
      chk("R3 R2 pattern", pat_out, (n <= 10) ? (8'h10 + n - 1) : (8'h40 + n - 11));
      chk("R3 flag", bank_flag, (n >= 10 && n < 20) ? 1 : 0);
      if (n == 9)  chk("R8 no strobe irq yet", irq, 0);
      if (n == 10) begin
        chk("R7 R8 strobe irq", irq, 1);
        clear_irq();
        chk("R9 clear", irq, 0);
      end
      if (n == 19) chk("R8 no match irq in strobe mode", irq, 0);
      if (n == 20) begin
        chk("R7 second strobe irq", irq, 1);
        clear_irq();
      end
    end

    // R4 single mode, match interrupt
    @(negedge clk); cfg_single_bank = 1'b1; cfg_irq_match = 1'b1;
    for (int k = 0; k < 3; k++) put(1'b1, k + 5, 8'hA0 + k);
    for (int k = 0; k < 3; k++) put(1'b0, k + 1, 8'h70 + k);
    for (int n = 1; n <= 3; n++) begin
      pulse();
      chk("R4 R5 pattern single", pat_out, 8'h70 + n - 1);
      chk("R4 flag single", bank_flag, 0);
      if (n == 1) begin
        chk("R8 match irq", irq, 1);
        clear_irq();
        chk("R9 clear match irq", irq, 0);
      end
    end
    put(1'b0, 1, 8'h73);
    pulse();
    chk("R5 counter cleared on wrap", pat_out, 8'h73);
    for (int n = 0; n < 5; n++) pulse();
    chk("R4 bank B ignored", pat_out, 8'h73);
    chk("R4 flag still A", bank_flag, 0);

    // R6 rewind
    @(negedge clk); cfg_single_bank = 1'b0;
    put(1'b0, 1, 8'hC0);
    pulse();
    chk("R6 pre pattern", pat_out, 8'hC0);
    chk("R3 flag to B", bank_flag, 1);
    @(negedge clk); cfg_single_bank = 1'b1;
    @(negedge clk); cfg_single_bank = 1'b0;
    @(negedge clk);
    chk("R6 flag rewound", bank_flag, 0);
    put(1'b0, 1, 8'hC1);
    pulse();
    chk("R6 counter cleared", pat_out, 8'hC1);
    chk("R6 flag B after A empties", bank_flag, 1);
    for (int n = 2; n <= 4; n++) pulse();
    chk("R2 holds between matches", pat_out, 8'hC1);
    pulse();
    chk("R3 bank B head", pat_out, 8'hA0);
    clear_irq();

    // R1 falling-edge counting
    @(negedge clk); cfg_fall_edge = 1'b1;
    half(1'b1);
    chk("R1 rising not counted", pat_out, 8'hA0);
    half(1'b0);
    chk("R1 falling counted", pat_out, 8'hA1);
    chk("R8 R9 match irq set", irq, 1);
    clear_irq();
    chk("R9 cleared", irq, 0);
    clear_irq();
    chk("R9 stays clear", irq, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule